// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between an interrupt distributor and one processor. The distributor offers a small set of candidate lanes, and each lane carries a valid flag, an interrupt ID, a priority and a source-CPU number. The block picks the most urgent lane. It raises an interrupt request when that lane beats a programmable priority mask and signalling is enabled. It answers register reads and writes from the processor on a simple 32-bit bus.

The processor reads the acknowledge register to take the selected interrupt. The block returns its ID, and for software-generated interrupts the ID of the requesting CPU as well. It marks the interrupt active and pulses an acknowledge strobe to the distributor, which moves the interrupt from pending to active. Writing the same value to the completion register ends the interrupt and pulses a completion strobe back to the distributor. Only one interrupt can be active at a time. While it is active the request output stays low, and further acknowledge reads return the spurious ID.

Register word offsets: 0x0 control (bit 0 enables signalling), 0x4 priority mask (bits 7:0), 0x8 acknowledge (read), 0xC completion (write).

Top module: `cpu_ack_if`

## Requirements
- R1: After reset the request output is low, the control and mask registers read as 0, and the strobes are low.
- R2: While control bit 0 is clear, the request output stays low whatever the candidates are.
- R3: A candidate is signalled only when its priority value is numerically strictly lower than the mask value. A priority equal to the mask, or a mask of 0, gives no request.
- R4: A read of offset 0x8 while a candidate qualifies returns that candidate's value in bits 13:0. One cycle later it pulses ack_stb_o with the ID and source, and it marks the interrupt active.
- R5: Among valid lanes the lowest priority value is selected. When priorities are equal, the lowest ID is selected.
- R6: For IDs below 16 the acknowledge value carries the candidate's source CPU in bits 13:10. For IDs of 16 and above those bits read 0, whatever source the lane carries.
- R7: When nothing qualifies, an acknowledge read returns 1023 (0x3FF), raises no strobe and changes no state.
- R8: A write to offset 0xC whose bits 13:0 equal the active interrupt's source and ID clears the active state. One cycle later it pulses eoi_stb_o with that ID and source.
- R9: A completion write whose ID or source does not match, or that arrives while nothing is active, is ignored: no strobe, and the active state is unchanged.
- R10: While an interrupt is active the request output is low, and acknowledge reads return 1023.
- R11: The control bit and the 8-bit mask read back at offsets 0x0 and 0x4 as written. Read data appears one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte address; bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| cand_valid | input | 4 | Per-lane candidate valid |
| cand_id | input | 40 | Per-lane 10-bit interrupt ID, lane i at bits [10i+9:10i] |
| cand_prio | input | 32 | Per-lane 8-bit priority, lower value is more urgent |
| cand_src | input | 16 | Per-lane 4-bit requesting CPU |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_stb_o | output | 1 | One-cycle acknowledge pulse to the distributor |
| ack_id_o | output | 10 | Acknowledged ID |
| ack_src_o | output | 4 | Acknowledged source CPU (0 for IDs of 16 and above) |
| eoi_stb_o | output | 1 | One-cycle completion pulse to the distributor |
| eoi_id_o | output | 10 | Completed ID |
| eoi_src_o | output | 4 | Completed source CPU |

## Verification
The bench builds the block with its default parameters: four lanes, 10-bit IDs, 8-bit priorities and 4-bit source numbers. With four lanes, one test can hold a strict priority winner, an equal-priority pair that the ID must decide, and a less urgent lane at the same time. Eight-bit priorities place the mask boundary at 0xF0 against 0xEF and 0xF0, and at 0. Sixteen is the boundary between software and peripheral IDs, so both the source-carrying and the source-cleared acknowledge values are reachable, as are matching and mismatching completion values.

// File: rtl/cpuif_pkg.sv
// Package: shared register map for the per-CPU acknowledge interface.
// Assumes the bus presents word-aligned byte addresses; bits 3:2 pick the word.
package cpuif_pkg;
    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_PMASK = 2'd1,
        REG_ACK   = 2'd2,
        REG_EOI   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/cpuif_select.sv
// Module: cpuif_select
// Picks the most urgent valid lane: lowest priority value, then lowest ID.
// Assumes the lanes carry distinct IDs. Purely combinational; the depth grows
// linearly with NLANES.
module cpuif_select #(
    parameter int NLANES = 4,
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8,
    parameter int SRC_W  = 4
) (
    input  logic [NLANES-1:0]        lane_v,
    input  logic [NLANES*ID_W-1:0]   lane_id,
    input  logic [NLANES*PRIO_W-1:0] lane_prio,
    input  logic [NLANES*SRC_W-1:0]  lane_src,
    output logic                     best_v,
    output logic [ID_W-1:0]          best_id,
    output logic [PRIO_W-1:0]        best_prio,
    output logic [SRC_W-1:0]         best_src
);
    // Linear scan keeping the current winner
    always_comb begin
        best_v    = 1'b0;
        best_id   = '0;
        best_prio = '0;
        best_src  = '0;
        for (int i = 0; i < NLANES; i++) begin
            if (lane_v[i] &&
                (!best_v ||
                 lane_prio[i*PRIO_W +: PRIO_W] < best_prio ||
                 (lane_prio[i*PRIO_W +: PRIO_W] == best_prio &&
                  lane_id[i*ID_W +: ID_W] < best_id))) begin
                best_v    = 1'b1;
                best_id   = lane_id[i*ID_W +: ID_W];
                best_prio = lane_prio[i*PRIO_W +: PRIO_W];
                best_src  = lane_src[i*SRC_W +: SRC_W];
            end
        end
    end
endmodule

// File: rtl/cpuif_active.sv
// Module: cpuif_active
// Holds the single active interrupt (ID and source). It sets on acknowledge and
// clears on a completion value that matches it exactly.
// Assumes set is only raised while no interrupt is active.
module cpuif_active #(
    parameter int ID_W  = 10,
    parameter int SRC_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set,
    input  logic [ID_W-1:0]       set_id,
    input  logic [SRC_W-1:0]      set_src,
    input  logic                  clr_req,
    input  logic [ID_W+SRC_W-1:0] clr_val,
    output logic                  act_v,
    output logic                  done_stb,
    output logic [ID_W-1:0]       done_id,
    output logic [SRC_W-1:0]      done_src
);
    logic [ID_W-1:0]  act_id;
    logic [SRC_W-1:0] act_src;
    logic             match;

    // Completion is accepted only for the exact active value
    assign match = act_v && (clr_val == {act_src, act_id});

    // Active slot update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_v   <= 1'b0;
            act_id  <= '0;
            act_src <= '0;
        end else if (set) begin
            act_v   <= 1'b1;
            act_id  <= set_id;
            act_src <= set_src;
        end else if (clr_req && match) begin
            act_v <= 1'b0;
        end
    end

    // Completion pulse towards the distributor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_stb <= 1'b0;
            done_id  <= '0;
            done_src <= '0;
        end else begin
            done_stb <= clr_req && match;
            if (clr_req && match) begin
                done_id  <= act_id;
                done_src <= act_src;
            end
        end
    end
endmodule

// File: rtl/cpu_ack_if.sv
// Module: cpu_ack_if (top)
// Per-CPU interrupt acknowledge interface: it masks the best candidate by
// priority, drives the request line, and serves the control, mask, acknowledge
// and completion registers. Assumes the distributor withdraws a lane once it
// sees ack_stb_o for it. One active interrupt at a time.
module cpu_ack_if #(
    parameter int NLANES    = 4,
    parameter int ID_W      = 10,
    parameter int PRIO_W    = 8,
    parameter int SRC_W     = 4,
    parameter int SGI_COUNT = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_rd,
    input  logic                     bus_wr,
    input  logic [3:0]               bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic [NLANES-1:0]        cand_valid,
    input  logic [NLANES*ID_W-1:0]   cand_id,
    input  logic [NLANES*PRIO_W-1:0] cand_prio,
    input  logic [NLANES*SRC_W-1:0]  cand_src,
    output logic                     irq_o,
    output logic                     ack_stb_o,
    output logic [ID_W-1:0]          ack_id_o,
    output logic [SRC_W-1:0]         ack_src_o,
    output logic                     eoi_stb_o,
    output logic [ID_W-1:0]          eoi_id_o,
    output logic [SRC_W-1:0]         eoi_src_o
);
    import cpuif_pkg::*;

    localparam int              VAL_W   = ID_W + SRC_W;
    localparam logic [ID_W-1:0] SPUR_ID = '1;
    localparam logic [ID_W-1:0] SGI_LIM = ID_W'(SGI_COUNT);

    logic              best_v;
    logic [ID_W-1:0]   best_id;
    logic [PRIO_W-1:0] best_prio;
    logic [SRC_W-1:0]  best_src;
    logic              en_q;
    logic [PRIO_W-1:0] pmask_q;
    logic              act_v;
    logic              qualify;
    logic              take;
    logic              eoi_req;
    reg_sel_e          word;
    logic [SRC_W-1:0]  ret_src;
    logic [VAL_W-1:0]  ack_val;

    cpuif_select #(
        .NLANES(NLANES), .ID_W(ID_W), .PRIO_W(PRIO_W), .SRC_W(SRC_W)
    ) u_select (
        .lane_v   (cand_valid),
        .lane_id  (cand_id),
        .lane_prio(cand_prio),
        .lane_src (cand_src),
        .best_v   (best_v),
        .best_id  (best_id),
        .best_prio(best_prio),
        .best_src (best_src)
    );

    // Qualification: enabled, strictly under the mask, no interrupt in service
    assign qualify = en_q && best_v && (best_prio < pmask_q) && !act_v;
    assign irq_o   = qualify;

    assign word    = reg_sel_e'(bus_addr[3:2]);
    assign take    = bus_rd && (word == REG_ACK) && qualify;
    assign eoi_req = bus_wr && (word == REG_EOI);
    assign ret_src = (best_id < SGI_LIM) ? best_src : '0;
    assign ack_val = take ? {ret_src, best_id} : {{SRC_W{1'b0}}, SPUR_ID};

    cpuif_active #(.ID_W(ID_W), .SRC_W(SRC_W)) u_active (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (take),
        .set_id  (best_id),
        .set_src (ret_src),
        .clr_req (eoi_req),
        .clr_val (bus_wdata[VAL_W-1:0]),
        .act_v   (act_v),
        .done_stb(eoi_stb_o),
        .done_id (eoi_id_o),
        .done_src(eoi_src_o)
    );

    // Configuration registers written by the processor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            pmask_q <= '0;
        end else if (bus_wr) begin
            if (word == REG_CTRL)  en_q    <= bus_wdata[0];
            if (word == REG_PMASK) pmask_q <= bus_wdata[PRIO_W-1:0];
        end
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (word)
                REG_CTRL:  bus_rdata <= {31'b0, en_q};
                REG_PMASK: bus_rdata <= {{(32-PRIO_W){1'b0}}, pmask_q};
                REG_ACK:   bus_rdata <= {{(32-VAL_W){1'b0}}, ack_val};
                default:   bus_rdata <= '0;
            endcase
        end
    end

    // Acknowledge pulse towards the distributor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_stb_o <= 1'b0;
            ack_id_o  <= '0;
            ack_src_o <= '0;
        end else begin
            ack_stb_o <= take;
            if (take) begin
                ack_id_o  <= best_id;
                ack_src_o <= ret_src;
            end
        end
    end
endmodule

// File: rtl/cpu_ack_if_chk.sv
// Module: cpu_ack_if_chk
// Temporal checks on the acknowledge interface, bound into cpu_ack_if.
module cpu_ack_if_chk #(
    parameter int ID_W      = 10,
    parameter int SRC_W     = 4,
    parameter int SGI_COUNT = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input logic             en_q,
    input logic             act_v,
    input logic             ack_stb_o,
    input logic [ID_W-1:0]  ack_id_o,
    input logic [SRC_W-1:0] ack_src_o,
    input logic             eoi_stb_o
);
    // R2
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> en_q);
    // R10
    active_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_v |-> !irq_o);
    // R4
    ack_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb_o |-> act_v);
    // R7
    ack_not_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb_o |-> (ack_id_o != {ID_W{1'b1}}));
    // R6
    periph_src_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb_o && ack_id_o >= ID_W'(SGI_COUNT)) |-> (ack_src_o == '0));
    // R8
    eoi_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_stb_o |-> (!act_v && $past(act_v)));
endmodule

bind cpu_ack_if cpu_ack_if_chk #(.ID_W(ID_W), .SRC_W(SRC_W), .SGI_COUNT(SGI_COUNT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_o    (irq_o),
    .en_q     (en_q),
    .act_v    (act_v),
    .ack_stb_o(ack_stb_o),
    .ack_id_o (ack_id_o),
    .ack_src_o(ack_src_o),
    .eoi_stb_o(eoi_stb_o)
);

// File: tb/cpu_ack_if_tb.sv
// Directed bench for cpu_ack_if: one task per scenario, each checking itself.
module cpu_ack_if_tb;
    localparam int NL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NL-1:0]    cand_valid = '0;
    logic [NL*10-1:0] cand_id = '0;
    logic [NL*8-1:0]  cand_prio = '0;
    logic [NL*4-1:0]  cand_src = '0;
    logic        irq_o, ack_stb_o, eoi_stb_o;
    logic [9:0]  ack_id_o, eoi_id_o;
    logic [3:0]  ack_src_o, eoi_src_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cpu_ack_if u_dut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cand_valid(cand_valid), .cand_id(cand_id), .cand_prio(cand_prio),
        .cand_src(cand_src), .irq_o(irq_o), .ack_stb_o(ack_stb_o),
        .ack_id_o(ack_id_o), .ack_src_o(ack_src_o), .eoi_stb_o(eoi_stb_o),
        .eoi_id_o(eoi_id_o), .eoi_src_o(eoi_src_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic set_lane(input int i, input logic v, input logic [9:0] id,
                            input logic [7:0] p, input logic [3:0] s);
        cand_valid[i]       = v;
        cand_id[i*10 +: 10] = id;
        cand_prio[i*8 +: 8] = p;
        cand_src[i*4 +: 4]  = s;
    endtask

    // Read: strobe one cycle, then sample data and ack pulse after the edge
    task automatic rd(input logic [3:0] a, output logic [31:0] d, output logic stb,
                      output logic [9:0] id, output logic [3:0] src);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata; stb = ack_stb_o; id = ack_id_o; src = ack_src_o;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, output logic stb,
                      output logic [9:0] id, output logic [3:0] src);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        stb = eoi_stb_o; id = eoi_id_o; src = eoi_src_o;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic s; logic [9:0] i; logic [3:0] c;
        chk("R1 irq", irq_o, 0);
        chk("R1 ack_stb", ack_stb_o, 0);
        chk("R1 eoi_stb", eoi_stb_o, 0);
        rd(4'h0, d, s, i, c); chk("R1 ctrl", d, 0);
        rd(4'h4, d, s, i, c); chk("R1 pmask", d, 0);
    endtask

    task automatic t_enable_mask();
        logic [31:0] d; logic s; logic [9:0] i; logic [3:0] c;
        set_lane(0, 1, 10'd40, 8'h10, 4'd0);
        wr(4'h4, 32'hF0, s, i, c);
        #1 chk("R2 irq low while disabled", irq_o, 0);
        wr(4'h0, 32'h1, s, i, c);
        #1 chk("R3 irq for 0x10 under 0xF0", irq_o, 1);
        rd(4'h0, d, s, i, c); chk("R11 ctrl readback", d, 1);
        rd(4'h4, d, s, i, c); chk("R11 pmask readback", d, 32'hF0);
        set_lane(0, 1, 10'd40, 8'hF0, 4'd0);
        #1 chk("R3 equal to mask blocked", irq_o, 0);
        set_lane(0, 1, 10'd40, 8'hEF, 4'd0);
        #1 chk("R3 just under mask", irq_o, 1);
        wr(4'h4, 32'h0, s, i, c);
        #1 chk("R3 mask zero blocks", irq_o, 0);
        wr(4'h4, 32'hF0, s, i, c);
        wr(4'h0, 32'h0, s, i, c);
        #1 chk("R2 cleared enable drops irq", irq_o, 0);
        wr(4'h0, 32'h1, s, i, c);
        set_lane(0, 0, 0, 0, 0);
    endtask

    task automatic t_arbitrate();
        logic [31:0] d; logic s; logic [9:0] i; logic [3:0] c;
        set_lane(0, 1, 10'd50, 8'h40, 0);
        set_lane(1, 1, 10'd70, 8'h20, 0);
        set_lane(2, 1, 10'd30, 8'h20, 0);
        set_lane(3, 1, 10'd20, 8'h80, 0);
        rd(4'h8, d, s, i, c);
        chk("R5 tie lowest ID value", d, 30);
        chk("R4 ack strobe", s, 1);
        chk("R4 ack id", i, 30);
        set_lane(2, 0, 0, 0, 0);
        #1 chk("R10 irq low while active", irq_o, 0);
        rd(4'h8, d, s, i, c);
        chk("R10 second ack spurious", d, 1023);
        chk("R10 second ack no strobe", s, 0);
        wr(4'hC, 32'd30, s, i, c);
        chk("R8 eoi strobe", s, 1);
        chk("R8 eoi id", i, 30);
        #1 chk("R8 irq back after eoi", irq_o, 1);
        rd(4'h8, d, s, i, c);
        chk("R5 next winner", d, 70);
        set_lane(1, 0, 0, 0, 0);
        wr(4'hC, 32'd70, s, i, c);
        rd(4'h8, d, s, i, c);
        chk("R5 priority over lower ID", d, 50);
        set_lane(0, 0, 0, 0, 0);
        wr(4'hC, 32'd50, s, i, c);
        set_lane(3, 0, 0, 0, 0);
    endtask

    task automatic t_sgi();
        logic [31:0] d; logic s; logic [9:0] i; logic [3:0] c;
        set_lane(1, 1, 10'd5, 8'h10, 4'd9);
        rd(4'h8, d, s, i, c);
        chk("R6 sgi value with source", d, (9 << 10) | 5);
        chk("R6 ack src", c, 9);
        set_lane(1, 0, 0, 0, 0);
        wr(4'hC, 32'd5, s, i, c);
        chk("R9 source mismatch ignored", s, 0);
        wr(4'hC, (32'd9 << 10) | 32'd6, s, i, c);
        chk("R9 id mismatch ignored", s, 0);
        set_lane(1, 1, 10'd90, 8'h10, 0);
        rd(4'h8, d, s, i, c);
        chk("R9 still active after ignored eoi", d, 1023);
        set_lane(1, 0, 0, 0, 0);
        wr(4'hC, (32'd9 << 10) | 32'd5, s, i, c);
        chk("R8 sgi eoi strobe", s, 1);
        chk("R8 sgi eoi src", c, 9);
        set_lane(2, 1, 10'd100, 8'h10, 4'd7);
        rd(4'h8, d, s, i, c);
        chk("R6 peripheral source cleared", d, 100);
        set_lane(2, 0, 0, 0, 0);
        wr(4'hC, 32'd100, s, i, c);
    endtask

    task automatic t_spurious();
        logic [31:0] d; logic s; logic [9:0] i; logic [3:0] c;
        rd(4'h8, d, s, i, c);
        chk("R7 empty ack spurious", d, 1023);
        chk("R7 empty ack no strobe", s, 0);
        wr(4'hC, 32'd1023, s, i, c);
        chk("R9 eoi with nothing active", s, 0);
        set_lane(3, 1, 10'd200, 8'h30, 0);
        #1 chk("R7 state unchanged, irq", irq_o, 1);
        rd(4'h8, d, s, i, c);
        chk("R7 ack after spurious", d, 200);
        set_lane(3, 0, 0, 0, 0);
        wr(4'hC, 32'd200, s, i, c);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_mask();
        t_arbitrate();
        t_sgi();
        t_spurious();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule